// File: doc/BRIEF.md
# Programming-Time Pad Clamp Controller

This block sits between the user logic and each user I/O pad and decides, every clock cycle, what the pad does. In normal operation the pad follows the user design's output and output-enable. While the device is being reprogrammed, each pin follows its own 2-bit clamp setting. A pin can float with its weak pull-up on, drive a fixed low, drive a fixed high, or keep the state it had when programming began. A real-time option lets the user design keep control of the pads during programming.

Two safety overrides take precedence over all modes. While a reconfiguration without a power cycle is in progress, every pad floats with its pull-up on. While the programming-complete status bit is clear, no pad drives. The pad controls are registered, so any input change reaches the pads one clock later. The held state is captured from the pad input value and the user output-enable. Capture happens only in the one cycle where the programming-active flag goes from low to high, and it happens even when an override is active in that cycle.

Top module: `isp_pad_clamp`

## Requirements
- R1: After reset, and until the first clock edge after reset release, every pin has output-enable 0, pull-up 1 and pad output 0.
- R2: When programming is inactive, the programming-complete bit is set and no reconfiguration is running, each pin's pad output equals the user output, its output-enable equals the user output-enable, and its pull-up is 0. These values appear one clock after the inputs.
- R3: During programming without real-time mode, a pin with clamp code 00 floats: output-enable 0, pull-up 1, pad output 0.
- R4: During programming without real-time mode, code 01 drives the pin low and code 10 drives it high. In both cases output-enable is 1 and pull-up is 0.
- R5: Code 11 drives the pad input value sampled when programming became active, provided the pin was then an output (user output-enable 1). In that case pull-up is 0.
- R6: Code 11 on a pin whose user output-enable was 0 at sampling time leaves it floating with pull-up 1 and pad output 0.
- R7: The held value is captured only in the cycle where the programming-active flag rises. Later pad or output-enable changes do not alter what a code-11 pin drives.
- R8: With real-time mode set, pads follow the user design during programming exactly as in R2.
- R9: While the programming-complete bit is 0 and no reconfiguration is running, every pin has output-enable 0, pull-up 1 and pad output 0, whatever its code or mode.
- R10: While reconfiguration is running, every pin has output-enable 0, pull-up 1 and pad output 0. This override takes precedence over all other conditions.
- R11: In the first clock after the programming-active flag falls, the pads again reflect the user signals, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| isp_active_i | input | 1 | Programming in progress |
| realtime_i | input | 1 | Real-time mode: user keeps pads during programming |
| reconfig_i | input | 1 | Reconfiguration without power cycle in progress |
| isp_done_i | input | 1 | Programming-complete status bit |
| clamp_cfg_i | input | 2*NPINS | Per-pin clamp code, pin p at bits [2p+1:2p] |
| user_o_i | input | NPINS | User output values |
| user_oe_i | input | NPINS | User output-enables |
| pad_i | input | NPINS | Pad input values |
| pad_o | output | NPINS | Pad output values |
| pad_oe_o | output | NPINS | Pad output-enables |
| pad_pu_o | output | NPINS | Weak pull-up enables |

## Verification
The risky coincidence is the rise of the programming-active flag, which must sample the hold value, happening in the same cycle as an override or as a code-11 pin that must already drive the value being sampled. The sweep runs through every combination of clamp codes and control flags, with random pad and user data. Many of those steps toggle the active flag while a reconfiguration or a clear programming-complete bit is also present. After each edge, every pad control is compared with a value computed from the rules. A directed sequence then raises the flag during a reconfiguration, lifts the override, and changes the pad inputs, and it expects the pads to show the values sampled at the rise.

// File: rtl/isp_clamp_pkg.sv
package isp_clamp_pkg;
  typedef enum logic [1:0] {
    CLAMP_TRI  = 2'b00,
    CLAMP_LOW  = 2'b01,
    CLAMP_HIGH = 2'b10,
    CLAMP_HOLD = 2'b11
  } clamp_mode_e;

  typedef struct packed {
    logic o;
    logic oe;
    logic pu;
  } pad_ctl_t;

  localparam pad_ctl_t PAD_FLOAT = '{o: 1'b0, oe: 1'b0, pu: 1'b1};
endpackage

// File: rtl/isp_entry_detect.sv
module isp_entry_detect (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  output logic rise_o
);
  logic active_q;

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= active_i;
  end

  assign rise_o = active_i & ~active_q;

  // R7: a rise is reported for one cycle only
  a_r7_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pin_hold_reg.sv
module pin_hold_reg (
  input  logic clk,
  input  logic rst,
  input  logic capture_i,
  input  logic val_i,
  input  logic oe_i,
  output logic hold_val_o,
  output logic hold_oe_o
);
  logic val_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (capture_i) begin
      val_q <= val_i;
      oe_q  <= oe_i;
    end
  end

  // the capture cycle already presents the live sample
  assign hold_val_o = capture_i ? val_i : val_q;
  assign hold_oe_o  = capture_i ? oe_i  : oe_q;

  // R7: stored sample changes only on a capture cycle
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !capture_i |=> ($stable(val_q) && $stable(oe_q)));
endmodule

// File: rtl/pin_clamp_cell.sv
module pin_clamp_cell
  import isp_clamp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       isp_active_i,
  input  logic       realtime_i,
  input  logic       reconfig_i,
  input  logic       isp_done_i,
  input  logic [1:0] mode_i,
  input  logic       user_o_i,
  input  logic       user_oe_i,
  input  logic       hold_val_i,
  input  logic       hold_oe_i,
  output logic       pad_o,
  output logic       pad_oe_o,
  output logic       pad_pu_o
);
  pad_ctl_t nxt, cur;
  logic     clamp_phase;

  assign clamp_phase = isp_active_i & ~realtime_i;

  always_comb begin
    nxt = PAD_FLOAT;
    if (reconfig_i || !isp_done_i) begin
      nxt = PAD_FLOAT;
    end else if (clamp_phase) begin
      unique case (clamp_mode_e'(mode_i))
        CLAMP_TRI:  nxt = PAD_FLOAT;
        CLAMP_LOW:  nxt = '{o: 1'b0, oe: 1'b1, pu: 1'b0};
        CLAMP_HIGH: nxt = '{o: 1'b1, oe: 1'b1, pu: 1'b0};
        CLAMP_HOLD: nxt = hold_oe_i ? '{o: hold_val_i, oe: 1'b1, pu: 1'b0}
                                    : PAD_FLOAT;
        default:    nxt = PAD_FLOAT;
      endcase
    end else begin
      nxt = '{o: user_o_i, oe: user_oe_i, pu: 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= PAD_FLOAT;
    else     cur <= nxt;
  end

  assign pad_o    = cur.o;
  assign pad_oe_o = cur.oe;
  assign pad_pu_o = cur.pu;

  a_r10_reconfig_float: assert property (@(posedge clk) disable iff (rst)
    reconfig_i |=> (!pad_oe_o && pad_pu_o));
  a_r9_done_gate: assert property (@(posedge clk) disable iff (rst)
    !isp_done_i |=> !pad_oe_o);
  a_r4_drive_low: assert property (@(posedge clk) disable iff (rst)
    (clamp_phase && isp_done_i && !reconfig_i && mode_i == 2'b01)
      |=> (pad_oe_o && !pad_o));
  a_r6_input_floats: assert property (@(posedge clk) disable iff (rst)
    (clamp_phase && isp_done_i && !reconfig_i && mode_i == 2'b11 && !hold_oe_i)
      |=> (!pad_oe_o && pad_pu_o));
  a_r2_user_follow: assert property (@(posedge clk) disable iff (rst)
    (!isp_active_i && isp_done_i && !reconfig_i)
      |=> (pad_oe_o == $past(user_oe_i) && !pad_pu_o));
  a_r3_no_contention: assert property (@(posedge clk) disable iff (rst)
    !(pad_oe_o && pad_pu_o));
endmodule

// File: rtl/isp_pad_clamp.sv
module isp_pad_clamp #(
  parameter int NPINS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               isp_active_i,
  input  logic               realtime_i,
  input  logic               reconfig_i,
  input  logic               isp_done_i,
  input  logic [2*NPINS-1:0] clamp_cfg_i,
  input  logic [NPINS-1:0]   user_o_i,
  input  logic [NPINS-1:0]   user_oe_i,
  input  logic [NPINS-1:0]   pad_i,
  output logic [NPINS-1:0]   pad_o,
  output logic [NPINS-1:0]   pad_oe_o,
  output logic [NPINS-1:0]   pad_pu_o
);
  localparam int CFG_W = 2;

  logic entry_rise;

  isp_entry_detect u_entry (
    .clk      (clk),
    .rst      (rst),
    .active_i (isp_active_i),
    .rise_o   (entry_rise)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic hv, hoe;

    pin_hold_reg u_hold (
      .clk        (clk),
      .rst        (rst),
      .capture_i  (entry_rise),
      .val_i      (pad_i[p]),
      .oe_i       (user_oe_i[p]),
      .hold_val_o (hv),
      .hold_oe_o  (hoe)
    );

    pin_clamp_cell u_cell (
      .clk          (clk),
      .rst          (rst),
      .isp_active_i (isp_active_i),
      .realtime_i   (realtime_i),
      .reconfig_i   (reconfig_i),
      .isp_done_i   (isp_done_i),
      .mode_i       (clamp_cfg_i[CFG_W*p +: CFG_W]),
      .user_o_i     (user_o_i[p]),
      .user_oe_i    (user_oe_i[p]),
      .hold_val_i   (hv),
      .hold_oe_i    (hoe),
      .pad_o        (pad_o[p]),
      .pad_oe_o     (pad_oe_o[p]),
      .pad_pu_o     (pad_pu_o[p])
    );
  end
endmodule

// File: tb/isp_pad_clamp_tb.sv
module isp_pad_clamp_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic isp = 1'b0, rt = 1'b0, rcf = 1'b0, done = 1'b0;
  logic [2*N-1:0] cfg = '0;
  logic [N-1:0] uo = '0, uoe = '0, pin = '0;
  logic [N-1:0] po, poe, ppu;

  int checks = 0, fails = 0;
  logic prev_isp = 1'b0;
  logic [N-1:0] m_hv = '0, m_hoe = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  isp_pad_clamp #(.NPINS(N)) u_dut (
    .clk(clk), .rst(rst), .isp_active_i(isp), .realtime_i(rt),
    .reconfig_i(rcf), .isp_done_i(done), .clamp_cfg_i(cfg),
    .user_o_i(uo), .user_oe_i(uoe), .pad_i(pin),
    .pad_o(po), .pad_oe_o(poe), .pad_pu_o(ppu));

  function automatic string tag_of(logic r, logic d, logic i, logic t, logic [1:0] m);
    if (r) return "R10";
    if (!d) return "R9";
    if (i && t) return "R8";
    if (!i) return "R2/R11";
    case (m)
      2'b00: return "R3";
      2'b11: return "R5/R6/R7";
      default: return "R4";
    endcase
  endfunction

  task automatic compare(string tag, int p, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s pin %0d: got {o,oe,pu}=%b expected %b", tag, p, got, exp);
    end
  endtask

  // apply inputs, wait one edge, compare every pin against the rules
  task automatic step(logic r, logic d, logic i, logic t, logic [2*N-1:0] c,
                      logic [N-1:0] u, logic [N-1:0] ue, logic [N-1:0] pi);
    logic rise;
    logic [2:0] exp [N];
    rcf = r; done = d; isp = i; rt = t; cfg = c; uo = u; uoe = ue; pin = pi;
    rise = i && !prev_isp;
    for (int p = 0; p < N; p++) begin
      logic hv, hoe;
      logic [1:0] m;
      hv  = rise ? pi[p] : m_hv[p];
      hoe = rise ? ue[p] : m_hoe[p];
      m   = c[2*p +: 2];
      if (r || !d)       exp[p] = 3'b001;
      else if (!i || t)  exp[p] = {u[p], ue[p], 1'b0};
      else if (m == 2'b01) exp[p] = 3'b010;
      else if (m == 2'b10) exp[p] = 3'b110;
      else if (m == 2'b11) exp[p] = hoe ? {hv, 2'b10} : 3'b001;
      else               exp[p] = 3'b001;
    end
    if (rise) begin m_hv = pi; m_hoe = ue; end
    prev_isp = i;
    @(posedge clk); #1;
    for (int p = 0; p < N; p++)
      compare(tag_of(r, d, i, t, c[2*p +: 2]), p, {po[p], poe[p], ppu[p]}, exp[p]);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    for (int p = 0; p < N; p++) compare("R1", p, {po[p], poe[p], ppu[p]}, 3'b001);
    rst = 1'b0;
    #4;  // still before first edge after release
    for (int p = 0; p < N; p++) compare("R1", p, {po[p], poe[p], ppu[p]}, 3'b001);

    // near-exhaustive sweep: every code combination times every control pattern
    for (int c = 0; c < 256; c++) begin
      for (int k = 0; k < 16; k++) begin
        step(k[3], k[2], k[1], k[0], c[7:0], 4'($urandom), 4'($urandom), 4'($urandom));
      end
    end

    // directed: rise during reconfiguration, then pad changes must not matter (R7)
    step(0, 1, 0, 0, 8'hFF, 4'b0000, 4'b1111, 4'b0000);
    step(1, 1, 1, 0, 8'hFF, 4'b0000, 4'b0111, 4'b0101);
    step(0, 1, 1, 0, 8'hFF, 4'b1111, 4'b1111, 4'b1010);
    step(0, 1, 1, 0, 8'hFF, 4'b0000, 4'b0000, 4'b1111);
    // exit returns to user control next cycle (R11)
    step(0, 1, 0, 0, 8'hFF, 4'b1001, 4'b1100, 4'b0000);
    // default codes float with pull-up (R3)
    step(0, 1, 1, 0, 8'h00, 4'b1111, 4'b1111, 4'b1111);
    step(0, 0, 1, 0, 8'h55, 4'b1111, 4'b1111, 4'b1111);  // R9
    step(0, 1, 1, 0, 8'hAA, 4'b0000, 4'b0000, 4'b0000);  // R4 high
    step(0, 1, 1, 1, 8'h55, 4'b0110, 4'b1011, 4'b0000);  // R8

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule